// File: doc/BRIEF.md
# Predicated Lane-Wise Vector Right Shifter

This block shifts every lane of a vector right by a per-lane count and fills the vacated high bits with zeros. The vector is split into lanes of 8, 16, 32 or 64 bits, and the lane width is chosen per operation. In the normal form, lane `e` of the count vector shifts lane `e` of the data vector. In the wide form, each lane takes its count from the 64-bit doubleword of the count vector that covers it.

A per-byte predicate chooses which lanes change. A lane whose predicate is inactive keeps its old value. The data input is also the destination, so the registered result is the new value of that same register.

Counts are not reduced modulo the lane width. Any count at or above the lane width clears the lane. The result and a one-cycle done pulse appear on the clock edge after a start strobe. A wide-form request with 64-bit lanes is rejected: it raises an illegal-op flag and leaves the data unchanged. The block has no condition-flag output.

Top module: `vec_rshift_pred`

## Requirements
- R1: An active lane is shifted right logically by its effective count, and every vacated high-order bit becomes 0.
- R2: The count of a lane is its full unsigned value and is never wrapped. Any count at or above the lane width gives an all-zero lane. For example, a 16-bit lane with count 0x0100 becomes zero and does not keep its value.
- R3: A lane is active when the predicate bit at index (e × W)/8 is 1, where W is the lane width in bits. That bit belongs to the lane's lowest byte. An inactive lane keeps its input value, and the predicate bits of the lane's other bytes have no effect.
- R4: `lane_sz` encodes the lane width as 00 = 8 bits, 01 = 16 bits, 10 = 32 bits and 11 = 64 bits. Lane `e` occupies bits [e × W + W − 1 : e × W].
- R5: With `wide_cnt` = 1, lane `e` uses the full 64-bit count held in bits [64k + 63 : 64k], where k = (e × W)/64. The saturation rule of R2 applies to that 64-bit value.
- R6: A start with `wide_cnt` = 1 and `lane_sz` = 11 is illegal. It raises `illegal_op` together with `done`, and the result equals the unmodified input vector.
- R7: On the rising edge after a cycle with `start` = 1, `result` and `done` update. `done` is high for exactly one cycle per start. `result` holds its value in every cycle with no start.
- R8: After reset, `result` is all zeros and both `done` and `illegal_op` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch one operation |
| wide_cnt | input | 1 | 1 = counts come from 64-bit doublewords |
| lane_sz | input | 2 | Lane width select |
| src_dst | input | VLEN | Data vector (old destination value) |
| shamt | input | VLEN | Count vector |
| pmask | input | VLEN/8 | Per-byte predicate |
| result | output | VLEN | Merged, shifted vector |
| done | output | 1 | One-cycle pulse when result is new |
| illegal_op | output | 1 | Rejected wide-form 64-bit request |

## Verification
A fault in one lane's count, saturation or predicate selection shows up in that lane's bits of `result` on the edge right after the start. Nothing is pipelined behind the output register. A wrong lane-to-doubleword mapping in the wide form corrupts only the lanes above the first doubleword, so the stimulus uses different counts in each doubleword. A stale or extra `done` pulse, or a `result` that changes without a start, appears within one cycle. The bench therefore compares every output on every clock.

// File: rtl/vec_rshift_pred.sv
module vec_rshift_pred #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_cnt,
  input  logic [1:0]        lane_sz,
  input  logic [VLEN-1:0]   src_dst,
  input  logic [VLEN-1:0]   shamt,
  input  logic [VLEN/8-1:0] pmask,
  output logic [VLEN-1:0]   result,
  output logic              done,
  output logic              illegal_op
);
  logic [VLEN-1:0] by_size [4];
  logic            bad_op;

  assign bad_op = wide_cnt && (lane_sz == 2'b11);

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int W = 8 << s;
    localparam int N = VLEN / W;
    logic [VLEN-1:0] res;

    for (genvar e = 0; e < N; e++) begin : g_lane
      localparam int DW = (e * W) / 64;
      logic [W-1:0] d, cn, q;
      logic [63:0]  cw;
      logic         act, sat;
      logic [6:0]   amt;

      assign d   = src_dst[e*W +: W];
      assign cn  = shamt[e*W +: W];
      assign cw  = shamt[DW*64 +: 64];
      assign act = pmask[(e*W)/8];
      assign sat = wide_cnt ? (cw >= 64'(W)) : (64'(cn) >= 64'(W));
      assign amt = wide_cnt ? cw[6:0] : 7'(cn);
      assign q   = sat ? '0 : (d >> amt);
      assign res[e*W +: W] = act ? q : d;
    end

    assign by_size[s] = res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      done       <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      done       <= start;
      illegal_op <= start && bad_op;
      if (start) result <= bad_op ? src_dst : by_size[lane_sz];
    end
  end
endmodule

module vec_rshift_pred_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wide_cnt,
  input logic [1:0]        lane_sz,
  input logic [VLEN-1:0]   src_dst,
  input logic [VLEN-1:0]   shamt,
  input logic [VLEN/8-1:0] pmask,
  input logic [VLEN-1:0]   result,
  input logic              done,
  input logic              illegal_op
);
  // R7: start is followed by done
  a_r7_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R7: no done without a start
  a_r7_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  // R7: result held when idle
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result));
  // R6: illegal flag accompanies done
  a_r6_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> done);
  // R6: illegal request leaves data untouched
  a_r6_illegal_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> result == $past(src_dst));
  // R3: lane 0 inactive keeps its lowest byte
  a_r3_lane0_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pmask[0]) |=> result[7:0] == $past(src_dst[7:0]));
  // R2: saturating count clears byte lane 0
  a_r2_byte_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wide_cnt && lane_sz == 2'b00 && pmask[0] && shamt[7:0] >= 8'd8)
      |=> result[7:0] == 8'h00);
endmodule

bind vec_rshift_pred vec_rshift_pred_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wide_cnt(wide_cnt),
  .lane_sz(lane_sz), .src_dst(src_dst), .shamt(shamt), .pmask(pmask),
  .result(result), .done(done), .illegal_op(illegal_op)
);

// File: tb/vec_rshift_pred_tb.sv
`timescale 1ns/1ps
module vec_rshift_pred_tb;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            wide_cnt = 1'b0;
  logic [1:0]      lane_sz = 2'b00;
  logic [VLEN-1:0] src_dst = '0;
  logic [VLEN-1:0] shamt = '0;
  logic [PW-1:0]   pmask = '0;
  logic [VLEN-1:0] result;
  logic            done, illegal_op;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R8";

  logic [VLEN-1:0] exp_res = '0;
  logic            exp_done = 1'b0;
  logic            exp_ill = 1'b0;

  always #5 clk = ~clk;

  vec_rshift_pred #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_cnt(wide_cnt),
    .lane_sz(lane_sz), .src_dst(src_dst), .shamt(shamt), .pmask(pmask),
    .result(result), .done(done), .illegal_op(illegal_op)
  );

  function automatic logic [VLEN-1:0] model(input logic [1:0] sz, input logic wd,
      input logic [VLEN-1:0] a, input logic [VLEN-1:0] b, input logic [PW-1:0] p);
    logic [VLEN-1:0] out;
    int w;
    w = 8 << sz;
    out = a;
    if (wd && sz == 2'b11) return a;
    for (int e = 0; e < VLEN / w; e++) begin
      logic [63:0] mask, d, c;
      logic [VLEN-1:0] t;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      t = a >> (e * w);
      d = t[63:0] & mask;
      if (wd) begin
        t = b >> (((e * w) / 64) * 64);
        c = t[63:0];
      end else begin
        t = b >> (e * w);
        c = t[63:0] & mask;
      end
      if (p[(e * w) / 8]) begin
        d = (c >= 64'(w)) ? 64'd0 : (d >> c);
        for (int k = 0; k < w; k++) out[e * w + k] = d[k];
      end
    end
    return out;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_res  <= '0;
      exp_done <= 1'b0;
      exp_ill  <= 1'b0;
    end else begin
      exp_done <= start;
      exp_ill  <= start && wide_cnt && lane_sz == 2'b11;
      if (start) exp_res <= model(lane_sz, wide_cnt, src_dst, shamt, pmask);
    end
  end

  always @(negedge clk) begin
    checks++;
    if (result !== exp_res || done !== exp_done || illegal_op !== exp_ill) begin
      failures++;
      $display("FAIL %s: result=%h done=%b ill=%b expected result=%h done=%b ill=%b",
               cur_req, result, done, illegal_op, exp_res, exp_done, exp_ill);
    end
  end

  task automatic check(input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic [1:0] sz, input logic wd,
                    input logic [VLEN-1:0] a, input logic [VLEN-1:0] b, input logic [PW-1:0] p);
    cur_req  = req;
    lane_sz  = sz;
    wide_cnt = wd;
    src_dst  = a;
    shamt    = b;
    pmask    = p;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    src_dst  = ~a;
    #1;
  endtask

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VLEN-1:0] rnd_cnt(input logic [1:0] sz, input logic wd);
    logic [VLEN-1:0] v;
    int w;
    w = wd ? 64 : (8 << sz);
    v = '0;
    for (int e = 0; e < VLEN / w; e++) begin
      logic [VLEN-1:0] c;
      int r;
      r = $urandom % 8;
      c = VLEN'($urandom % (w + 4));
      if (r == 0) c = VLEN'(w) << (($urandom % 2) * 4);
      if (r == 1) c = VLEN'($urandom) << (w / 2);
      v = v | (c << (e * w));
    end
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", {result[VLEN-1:2], done, illegal_op}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4: byte lanes 0xF0 >> 4 = 0x0F
    op("R1", 2'b00, 1'b0, {PW{8'hF0}}, {PW{8'h04}}, '1);
    check("R1", result, {PW{8'h0F}});
    // R4: word lanes
    op("R4", 2'b10, 1'b0, {(VLEN/32){32'h8000_0001}}, {(VLEN/32){32'd31}}, '1);
    check("R4", result, {(VLEN/32){32'h0000_0001}});
    // R2: halfword count 0x0100 is not wrapped
    op("R2", 2'b01, 1'b0, {(VLEN/16){16'hFFFF}}, {(VLEN/16){16'h0100}}, '1);
    check("R2", result, '0);
    op("R2", 2'b01, 1'b0, {(VLEN/16){16'hFFFF}}, {(VLEN/16){16'h000F}}, '1);
    check("R2", result, {(VLEN/16){16'h0001}});
    // R3: only odd predicate bits set with halfword lanes: nothing changes
    op("R3", 2'b01, 1'b0, {(VLEN/16){16'hABCD}}, {(VLEN/16){16'h0004}}, {(PW/2){2'b10}});
    check("R3", result, {(VLEN/16){16'hABCD}});
    // R5: wide form, doubleword k holds count k+1, byte lanes
    begin
      logic [VLEN-1:0] b, ex;
      for (int k = 0; k < VLEN / 64; k++) b[k*64 +: 64] = 64'(k + 1);
      for (int k = 0; k < VLEN / 64; k++) ex[k*64 +: 64] = {8{8'hFF >> (k + 1)}};
      op("R5", 2'b00, 1'b1, {PW{8'hFF}}, b, '1);
      check("R5", result, ex);
    end
    // R6: illegal wide 64-bit
    op("R6", 2'b11, 1'b1, {(VLEN/32){32'h1234_5678}}, {(VLEN/32){32'd1}}, '1);
    check("R6", {result, done, illegal_op}, {{(VLEN/32){32'h1234_5678}}, 2'b11});
    // R7: idle cycles hold result, done low
    cur_req = "R7";
    @(negedge clk);
    check("R7", {result, done}, {{(VLEN/32){32'h1234_5678}}, 1'b0});
    repeat (2) @(negedge clk);

    // random sweep across sizes and forms, compared every clock
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      logic wd;
      sz = 2'($urandom);
      wd = ($urandom % 3) == 0;
      op(wd ? "R5" : "R1", sz, wd, rnd_vec(), rnd_cnt(sz, wd), PW'(rnd_vec()));
      if ($urandom % 4 == 0) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule